// File: doc/BRIEF.md
# Timer Output Compare Unit

An 8-bit timer/counter with one compare channel. The counter advances only on cycles where the timer enable input is high. On each such tick an equality comparator checks the counter against an active compare register. A hit raises an interrupt-request flag and drives a small waveform generator, which sets, clears or toggles an output pin.

The CPU programs the block through a single write port that selects one of five targets:

| Address | Target |
|---|---|
| 0 | counter |
| 1 | compare value |
| 2 | configuration byte |
| 3 | force strobe |
| 4 | flag-clear strobe |

Four waveform modes are supported: free-running, clear-on-match, fast PWM and phase-correct PWM. In the two PWM modes the compare value is double buffered, so the pulse width changes only at a period boundary. Outside the PWM modes, software can fire a compare action by hand. After any counter write, the comparator is blinded for the following tick.

Top module: `ocu_timer`

## Requirements
- R1: After reset the counter, the active compare value, the flag and the pin are all 0. The mode is free-running (waveform code 00) and the output action is off (action code 00).
- R2: The configuration byte holds the waveform code in bits 1:0 and the action code in bits 3:2. The counter changes only on ticks (`tick_en` high) or on a write to address 0. In waveform 00 (free-running) and 11 (fast PWM) it increments and wraps from 255 to 0.
- R3: In waveform 10 (clear-on-match), a tick on which the counter equals the compare value loads 0 into the counter, so the count period is compare value + 1.
- R4: In waveform 01 (phase-correct), the counter runs 0 up to 255 and then back down to 0, giving a 510-tick period.
- R5: A match raises `flag_o` on the next cycle. Writing a 1 in bit 0 to address 4 clears it. A match in the same cycle as the clear wins, and the flag stays set.
- R6: In waveforms 00 and 10, a write to address 1 reaches the active compare value on the next cycle.
- R7: In waveforms 01 and 11, a write to address 1 goes to a buffer. The buffer is copied to the active compare value only on a tick while the counter is 255.
- R8: In waveforms 00 and 10, a match applies the action code to the pin: 01 toggles it, 10 clears it and 11 sets it.
- R9: In fast PWM, action 10 clears the pin on a match and sets it on the 255→0 wrap, and the wrap wins when both fall on one tick. The pin is high for compare value + 1 of every 256 ticks. Action 11 inverts this.
- R10: In phase-correct PWM, action 10 clears the pin on a match while counting up and sets it on a match while counting down. For a compare value v between 1 and 254, the pin is low for 2·(255−v) of every 510 ticks.
- R11: Writing a 1 in bit 0 to address 3 in waveform 00 or 10 applies the action code to the pin at once. It leaves the flag and the counter unchanged. In the PWM waveforms the strobe has no effect on the pin.
- R12: A write to the counter suppresses any match on the next tick, however many idle cycles pass before that tick.
- R13: With action code 00 the pin keeps its last value through matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer clock enable; one tick per high cycle |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 3 | Write target: 0 counter, 1 compare, 2 config, 3 force, 4 flag clear |
| wr_data | input | 8 | Write data |
| cnt_o | output | 8 | Current counter value |
| cmp_o | output | 8 | Active compare value |
| flag_o | output | 1 | Compare interrupt request flag |
| pin_o | output | 1 | Waveform output pin |

## Verification
The hardest situations to reach from the ports are a match that lands in the very cycle of a flag-clear write, and a match that a counter write should hide after the timer has sat idle. The bench reaches both by parking the counter with a direct write, spending the blinded tick on purpose, and then stepping single ticks. This lets it put the equal-valued tick exactly where it is wanted, alone or together with a clear strobe. The PWM duty checks sweep compare values that include both ends of the range. The bench counts pin-high samples over a full period and compares the count with the closed-form duty.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    WM_NORMAL = 2'b00,
    WM_PHASE  = 2'b01,
    WM_CTC    = 2'b10,
    WM_FAST   = 2'b11
  } wave_t;

  typedef enum logic [1:0] {
    CO_OFF    = 2'b00,
    CO_TOGGLE = 2'b01,
    CO_CLEAR  = 2'b10,
    CO_SET    = 2'b11
  } cout_t;

  localparam logic [ADDR_W-1:0] A_COUNT = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMP   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CFG   = 3'd2;
  localparam logic [ADDR_W-1:0] A_FORCE = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAG  = 3'd4;

  function automatic logic is_pwm(input wave_t m);
    return (m == WM_PHASE) || (m == WM_FAST);
  endfunction

  // Pin after a non-PWM compare action.
  function automatic logic apply_action(input cout_t c, input logic cur);
    case (c)
      CO_TOGGLE: return ~cur;
      CO_CLEAR:  return 1'b0;
      CO_SET:    return 1'b1;
      default:   return cur;
    endcase
  endfunction
endpackage

// File: rtl/ocu_counter.sv
module ocu_counter
  import ocu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  wave_t        mode,
  input  logic         hit,
  output logic [W-1:0] cnt,
  output logic         dir_up
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  // Returns {direction, next count} for one tick.
  function automatic logic [W:0] advance(input logic [W-1:0] c, input logic up,
                                         input wave_t m, input logic h);
    logic [W-1:0] n;
    logic u;
    n = c + ONE;
    u = up;
    case (m)
      WM_CTC: if (h) n = '0;
      WM_PHASE: begin
        if (up) begin
          if (c == TOP) begin
            n = TOP - ONE;
            u = 1'b0;
          end
        end else if (c == '0) begin
          n = ONE;
          u = 1'b1;
        end else begin
          n = c - ONE;
        end
      end
      default: ;
    endcase
    return {u, n};
  endfunction

  logic [W:0] nxt;
  assign nxt = advance(cnt, dir_up, mode, hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else if (wr) begin
      cnt <= wdata;
    end else if (tick) begin
      cnt    <= nxt[W-1:0];
      dir_up <= nxt[W];
    end
  end
endmodule

// File: rtl/ocu_compare.sv
module ocu_compare #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic         cmp_wr,
  input  logic [W-1:0] wdata,
  input  logic         pwm,
  input  logic         load,
  input  logic         cnt_wr,
  output logic [W-1:0] cmp,
  output logic         hit
);
  logic [W-1:0] shadow;
  logic         blind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      cmp    <= '0;
    end else begin
      if (cmp_wr) shadow <= wdata;
      if (cmp_wr && !pwm) cmp <= wdata;
      else if (pwm && load) cmp <= shadow;
    end
  end

  // A counter write blinds the comparator until one tick has passed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blind <= 1'b0;
    else if (cnt_wr) blind <= 1'b1;
    else if (tick) blind <= 1'b0;
  end

  assign hit = tick && (cnt == cmp) && !blind;
endmodule

// File: rtl/ocu_wavegen.sv
module ocu_wavegen
  import ocu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  wave_t mode,
  input  cout_t act,
  input  logic  hit,
  input  logic  force_ev,
  input  logic  wrap,
  input  logic  dir_up,
  output logic  pin
);
  logic nxt;

  always_comb begin
    nxt = pin;
    case (mode)
      WM_FAST: begin
        if (act == CO_CLEAR) begin
          if (hit) nxt = 1'b0;
          if (wrap) nxt = 1'b1;
        end else if (act == CO_SET) begin
          if (hit) nxt = 1'b1;
          if (wrap) nxt = 1'b0;
        end
      end
      WM_PHASE: begin
        if (hit && act == CO_CLEAR) nxt = !dir_up;
        else if (hit && act == CO_SET) nxt = dir_up;
      end
      default: if (hit || force_ev) nxt = apply_action(act, pin);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin <= 1'b0;
    else pin <= nxt;
  end
endmodule

// File: rtl/ocu_timer.sv
module ocu_timer
  import ocu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      cnt_o,
  output logic [W-1:0]      cmp_o,
  output logic              flag_o,
  output logic              pin_o
);
  localparam logic [W-1:0] TOP = '1;

  wave_t wave_q;
  cout_t act_q;
  logic  cnt_wr, cmp_wr, cfg_wr, force_ev, clr_ev;
  logic  match_ev, top_ev, dir_up, pwm_on;

  assign cnt_wr   = wr_en && (wr_addr == A_COUNT);
  assign cmp_wr   = wr_en && (wr_addr == A_CMP);
  assign cfg_wr   = wr_en && (wr_addr == A_CFG);
  assign force_ev = wr_en && (wr_addr == A_FORCE) && wr_data[0];
  assign clr_ev   = wr_en && (wr_addr == A_FLAG) && wr_data[0];
  assign pwm_on   = is_pwm(wave_q);
  assign top_ev   = tick_en && (cnt_o == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_q <= WM_NORMAL;
      act_q  <= CO_OFF;
    end else if (cfg_wr) begin
      wave_q <= wave_t'(wr_data[1:0]);
      act_q  <= cout_t'(wr_data[3:2]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else if (match_ev) flag_o <= 1'b1;
    else if (clr_ev) flag_o <= 1'b0;
  end

  ocu_counter #(.W(W)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .wr(cnt_wr), .wdata(wr_data),
    .mode(wave_q), .hit(match_ev), .cnt(cnt_o), .dir_up(dir_up)
  );

  ocu_compare #(.W(W)) u_compare (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .cnt(cnt_o), .cmp_wr(cmp_wr),
    .wdata(wr_data), .pwm(pwm_on), .load(top_ev), .cnt_wr(cnt_wr),
    .cmp(cmp_o), .hit(match_ev)
  );

  ocu_wavegen u_wavegen (
    .clk(clk), .rst_n(rst_n), .mode(wave_q), .act(act_q), .hit(match_ev),
    .force_ev(force_ev), .wrap(top_ev), .dir_up(dir_up), .pin(pin_o)
  );
endmodule

// File: rtl/ocu_timer_chk.sv
module ocu_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_en,
  input logic         match_ev,
  input logic         cnt_wr,
  input logic         cfg_wr,
  input logic         force_ev,
  input logic         top_ev,
  input logic         pwm_on,
  input logic [1:0]   wave,
  input logic [1:0]   act,
  input logic [W-1:0] cnt,
  input logic [W-1:0] cmp,
  input logic         flag,
  input logic         pin
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cnt_wr) |=> $stable(cnt));

  p_ctc_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wave == 2'b10 && match_ev && !cnt_wr) |=> (cnt == '0));

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev |=> flag);

  p_buffered_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_on && !top_ev) |=> $stable(cmp));

  p_force_noflag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (force_ev && !match_ev && !flag) |=> !flag);

  p_blind_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> !match_ev);

  p_off_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (act == 2'b00 && !cfg_wr) |=> $stable(pin));
endmodule

bind ocu_timer ocu_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .match_ev(match_ev),
  .cnt_wr(cnt_wr), .cfg_wr(cfg_wr), .force_ev(force_ev), .top_ev(top_ev),
  .pwm_on(pwm_on), .wave(wave_q), .act(act_q), .cnt(cnt_o), .cmp(cmp_o),
  .flag(flag_o), .pin(pin_o)
);

// File: tb/ocu_timer_bench.sv
module ocu_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] cnt_o, cmp_o;
  logic       flag_o, pin_o;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ocu_timer u_ocu_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_o(cnt_o), .cmp_o(cmp_o), .flag_o(flag_o), .pin_o(pin_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input bit with_tick = 0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick_en = with_tick;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  function automatic int pc_cnt(input int n);
    int m = n % 510;
    return (m <= 255) ? m : 510 - m;
  endfunction

  task automatic fast_duty(input int v, input int act, input int exp_hi);
    int hi = 0;
    do_reset();
    wr(3'd2, 8'(3 | (act << 2)));
    wr(3'd1, 8'(v));
    chk("R7 buffered before top", cmp_o, 0);
    ticks(512);
    chk("R7 buffer loaded", cmp_o, v);
    for (int i = 0; i < 256; i++) begin
      ticks(1);
      hi += pin_o;
    end
    chk($sformatf("R9 fast duty v=%0d act=%0d", v, act), hi, exp_hi);
  endtask

  task automatic phase_duty(input int v);
    int lo = 0;
    do_reset();
    wr(3'd2, 8'(1 | (2 << 2)));
    wr(3'd1, 8'(v));
    ticks(1020);
    for (int i = 0; i < 510; i++) begin
      ticks(1);
      lo += !pin_o;
    end
    chk($sformatf("R10 phase duty v=%0d", v), lo, 2 * (255 - v));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 cnt", cnt_o, 0); chk("R1 cmp", cmp_o, 0);
    chk("R1 flag", flag_o, 0); chk("R1 pin", pin_o, 0);

    // R2 free-running wrap and hold without ticks
    ticks(300);
    chk("R2 wrap count", cnt_o, 300 % 256);
    repeat (5) @(negedge clk);
    chk("R2 hold when stopped", cnt_o, 300 % 256);

    // R3 / R8 clear-on-match with toggle
    do_reset();
    wr(3'd2, 8'(2 | (1 << 2)));
    wr(3'd1, 8'd5);
    chk("R6 direct compare", cmp_o, 5);
    wr(3'd0, 8'd0);
    for (int n = 1; n <= 30; n++) begin
      ticks(1);
      chk($sformatf("R3 ctc cnt n=%0d", n), cnt_o, n % 6);
      chk($sformatf("R8 toggle n=%0d", n), pin_o, (n / 6) % 2);
      chk($sformatf("R5 flag n=%0d", n), flag_o, (n >= 6) ? 1 : 0);
    end

    // R4 phase-correct counting
    do_reset();
    wr(3'd2, 8'd1);
    for (int n = 1; n <= 600; n++) begin
      ticks(1);
      chk($sformatf("R4 phase cnt n=%0d", n), cnt_o, pc_cnt(n));
    end

    // R9 fast PWM duty sweep, including ends
    fast_duty(0, 2, 1);
    fast_duty(1, 2, 2);
    fast_duty(100, 2, 101);
    fast_duty(254, 2, 255);
    fast_duty(255, 2, 256);
    fast_duty(100, 3, 155);

    // R10 phase-correct duty
    phase_duty(1);
    phase_duty(100);
    phase_duty(200);

    // R11 / R8 force in clear-on-match mode
    do_reset();
    wr(3'd2, 8'(2 | (1 << 2)));
    wr(3'd1, 8'd200);
    wr(3'd3, 8'd1);
    chk("R11 force toggles pin", pin_o, 1);
    chk("R11 force leaves flag", flag_o, 0);
    chk("R11 force leaves cnt", cnt_o, 0);
    wr(3'd3, 8'd1);
    chk("R8 toggle back", pin_o, 0);
    wr(3'd2, 8'(2 | (3 << 2)));
    wr(3'd3, 8'd1);
    chk("R8 set action", pin_o, 1);
    wr(3'd2, 8'(2 | (2 << 2)));
    wr(3'd3, 8'd1);
    chk("R8 clear action", pin_o, 0);
    wr(3'd2, 8'(3 | (3 << 2)));
    wr(3'd3, 8'd1);
    chk("R11 force ignored in PWM", pin_o, 0);

    // R12 blinding after counter write, even when stopped
    do_reset();
    wr(3'd1, 8'd10);
    wr(3'd0, 8'd10);
    repeat (3) @(negedge clk);
    ticks(1);
    chk("R12 blinded match cnt", cnt_o, 11);
    chk("R12 blinded match flag", flag_o, 0);
    wr(3'd0, 8'd9);
    ticks(1);
    chk("R12 no match yet", flag_o, 0);
    ticks(1);
    chk("R12 later match seen", flag_o, 1);

    // R5 clear, then match-and-clear in one cycle
    wr(3'd4, 8'd1);
    chk("R5 flag cleared", flag_o, 0);
    wr(3'd0, 8'd8);
    ticks(1);
    ticks(1);
    chk("R5 cnt staged", cnt_o, 10);
    wr(3'd4, 8'd1, 1);
    chk("R5 match beats clear", flag_o, 1);

    // R13 action off holds pin
    do_reset();
    wr(3'd2, 8'(2 | (3 << 2)));
    wr(3'd3, 8'd1);
    wr(3'd2, 8'd2);
    wr(3'd1, 8'd3);
    wr(3'd0, 8'd0);
    ticks(20);
    chk("R13 matches occurred", flag_o, 1);
    chk("R13 pin held", pin_o, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule